// File: doc/BRIEF.md
# Integer and Floating-Point Conversion Unit

This block converts one lane in either direction between integers and IEEE-754 floating point. In the integer-to-float direction it takes a 32-bit signed or unsigned integer and produces a binary32 or binary16 value. Rounding follows a 2-bit mode input. In the float-to-int direction it takes a binary32 or binary16 value and produces a 32-bit signed or unsigned integer. That direction always truncates toward zero and clamps values that fall out of range.

The signed and unsigned integer paths share one normalize-and-round datapath. They differ only in a prologue that takes the magnitude of a negative signed operand and records its sign. Each format has its own converter instance, chosen by a generate loop. The selected result is registered once, so a result appears one clock after its operands.

Top module: `cvt_unit`

## Requirements
- R1: `result_o` is registered. The result for the operands present at a rising clock edge appears after that edge. While `rst_ni` is low, `result_o` is 0.
- R2: The `op_i` encoding is: 2'b00 signed int to float, 2'b01 unsigned int to float, 2'b10 float to signed int, 2'b11 float to unsigned int. With `fmt_i` = 0 the float is binary32 (8-bit exponent, bias 127, 23-bit fraction). With `fmt_i` = 1 it is binary16 (5-bit exponent, bias 15, 10-bit fraction). A binary16 input is read from `operand_i[15:0]`, and a binary16 output drives `result_o[15:0]` with the upper bits set to 0.
- R3: Signed int to float treats `operand_i` as two's complement. A negative value sets the sign bit and converts its magnitude, so 0x80000000 gives 0xCF000000 in binary32. Unsigned int to float treats all 32 bits as magnitude and never sets the sign bit, so 0x80000000 gives 0x4F000000.
- R4: An integer operand of zero gives +0.0 (all zero bits) in every mode and for both signednesses.
- R5: The `mode_i` encoding is: 0 round to nearest with ties to even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. The bits dropped by normalization decide the rounding. Example: unsigned 0xFFFFFFFF gives 0x4F800000 in mode 0 and 0x4F7FFFFF in mode 1.
- R6: If the biased exponent after rounding reaches all ones, the result is a signed infinity in every mode: 0x7F800000 or 0xFF800000 for binary32, 0x7C00 or 0xFC00 for binary16. Example: binary16 from 65519 gives 0x7BFF and from 65520 gives 0x7C00 in mode 0.
- R7: Float to int truncates toward zero, and `mode_i` has no effect on the result.
- R8: Signed float to int saturates. Values at or above 2^31 and +infinity give 0x7FFFFFFF. Values at or below -2^31-1 and -infinity give 0x80000000. A NaN gives 0x80000000.
- R9: Unsigned float to int gives 0 for any negative input (including -infinity) and for NaN. It gives 0xFFFFFFFF for values at or above 2^32 and for +infinity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 2 | Operation select (R2) |
| fmt_i | input | 1 | Float format: 0 binary32, 1 binary16 |
| mode_i | input | 2 | Rounding mode for int to float (R5) |
| operand_i | input | INT_W | Integer or float operand |
| result_o | output | INT_W | Registered float or integer result |

## Verification
Two functions can fire in the same cycle: the rounding increment and the exponent overflow. When a rounding carry ripples out of an all-ones fraction, it raises the exponent into the infinity code. Binary16 conversions of 65519, 65520 and their negative counterparts provoke this in each mode. The results are judged against a bench model that rounds by quotient and remainder arithmetic. A dense sweep of signed integers into binary16 across all four modes then crosses the carry point many times. The float-to-int side is swept over every binary16 code, cycling the mode input, against a real-number truncation model.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  typedef enum logic [1:0] {
    OP_FLOAT  = 2'b00,
    OP_UFLOAT = 2'b01,
    OP_TRUNC  = 2'b10,
    OP_UTRUNC = 2'b11
  } cvt_op_e;

  typedef enum logic [1:0] {
    RM_RNE = 2'd0,
    RM_RTZ = 2'd1,
    RM_RUP = 2'd2,
    RM_RDN = 2'd3
  } rnd_mode_e;

  localparam int NUM_FMT = 2;

  function automatic int fmt_exp_w(int f);
    return (f == 0) ? 8 : 5;
  endfunction

  function automatic int fmt_man_w(int f);
    return (f == 0) ? 23 : 10;
  endfunction
endpackage

// File: rtl/cvt_lzc.sv
module cvt_lzc #(
  parameter int W    = 32,
  parameter int LZ_W = $clog2(W)
) (
  input  logic [W-1:0]    vec_i,
  output logic [LZ_W-1:0] cnt_o,
  output logic            zero_o
);
  // highest set bit wins (last assignment)
  always_comb begin
    cnt_o  = '0;
    zero_o = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        cnt_o  = LZ_W'(W - 1 - i);
        zero_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cvt_int_to_fp.sv
module cvt_int_to_fp
  import cvt_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [INT_W-1:0]         mag_i,
  input  logic                     neg_i,
  input  logic [1:0]               mode_i,
  output logic [EXP_W+MAN_W:0]     res_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int LZ_W = $clog2(INT_W);
  localparam int EW   = EXP_W + LZ_W;
  localparam int EMAX = (1 << EXP_W) - 1;

  logic [LZ_W-1:0]  lz;
  logic             is_zero;
  logic [INT_W-2:0] norm;
  logic [MAN_W-1:0] mant;
  logic             g_bit, r_bit, s_bit, inexact, rnd_up;
  logic [MAN_W:0]   mant_sum;
  logic [EW-1:0]    exp_b;
  logic             ovf;

  cvt_lzc #(.W(INT_W)) u_lzc (
    .vec_i  (mag_i),
    .cnt_o  (lz),
    .zero_o (is_zero)
  );

  // leading one dropped; remaining bits hold fraction then guard/round/sticky
  assign norm    = (INT_W-1)'(mag_i << lz);
  assign mant    = norm[INT_W-2 -: MAN_W];
  assign g_bit   = norm[INT_W-2-MAN_W];
  assign r_bit   = norm[INT_W-3-MAN_W];
  assign s_bit   = |norm[INT_W-4-MAN_W:0];
  assign inexact = g_bit | r_bit | s_bit;

  always_comb begin
    unique case (rnd_mode_e'(mode_i))
      RM_RNE:  rnd_up = g_bit & (r_bit | s_bit | mant[0]);
      RM_RTZ:  rnd_up = 1'b0;
      RM_RUP:  rnd_up = ~neg_i & inexact;
      default: rnd_up = neg_i & inexact;
    endcase
  end

  assign mant_sum = {1'b0, mant} + (MAN_W+1)'(rnd_up);
  assign exp_b    = EW'(INT_W - 1) - EW'(lz) + EW'(BIAS) + EW'(mant_sum[MAN_W]);
  assign ovf      = exp_b >= EW'(EMAX);

  always_comb begin
    if (is_zero)  res_o = '0;
    else if (ovf) res_o = {neg_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else          res_o = {neg_i, exp_b[EXP_W-1:0], mant_sum[MAN_W-1:0]};
  end
endmodule

// File: rtl/cvt_fp_to_int.sv
module cvt_fp_to_int #(
  parameter int INT_W = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] fp_i,
  input  logic                 uns_i,
  output logic [INT_W-1:0]     int_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int WIDE = INT_W + MAN_W + 1;
  localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};

  logic             sgn;
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             special, is_nan, big;
  logic [WIDE-1:0]  shifted;
  logic [INT_W-1:0] mag;
  int               ue;

  assign sgn     = fp_i[EXP_W+MAN_W];
  assign exp_f   = fp_i[MAN_W +: EXP_W];
  assign man_f   = fp_i[MAN_W-1:0];
  assign special = &exp_f;
  assign is_nan  = special & (|man_f);

  // fraction bits fall off the bottom: truncation toward zero
  always_comb begin
    ue      = int'(exp_f) - BIAS;
    big     = ue >= INT_W;
    shifted = '0;
    mag     = '0;
    if (ue >= 0 && !big) begin
      shifted = WIDE'({1'b1, man_f}) << ue;
      mag     = INT_W'(shifted >> MAN_W);
    end
  end

  always_comb begin
    if (uns_i) begin
      if (is_nan || sgn)      int_o = '0;
      else if (special | big) int_o = '1;
      else                    int_o = mag;
    end else begin
      if (is_nan)             int_o = SMIN;
      else if (special | big) int_o = sgn ? SMIN : SMAX;
      else if (sgn)           int_o = (mag[INT_W-1] && |mag[INT_W-2:0]) ? SMIN : -mag;
      else                    int_o = mag[INT_W-1] ? SMAX : mag;
    end
  end
endmodule

// File: rtl/cvt_unit.sv
module cvt_unit
  import cvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       op_i,
  input  logic             fmt_i,
  input  logic [1:0]       mode_i,
  input  logic [INT_W-1:0] operand_i,
  output logic [INT_W-1:0] result_o
);
  logic             neg;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] i2f_res [NUM_FMT];
  logic [INT_W-1:0] f2i_res [NUM_FMT];
  logic [INT_W-1:0] res_d;

  // sign-magnitude prologue only for the signed form
  assign neg = (cvt_op_e'(op_i) == OP_FLOAT) && operand_i[INT_W-1];
  assign mag = neg ? -operand_i : operand_i;

  for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
    localparam int EW_F = fmt_exp_w(f);
    localparam int MW_F = fmt_man_w(f);
    localparam int FP_W = 1 + EW_F + MW_F;
    logic [FP_W-1:0]  fp_res;
    logic [INT_W-1:0] int_res;

    cvt_int_to_fp #(.INT_W(INT_W), .EXP_W(EW_F), .MAN_W(MW_F)) u_i2f (
      .mag_i  (mag),
      .neg_i  (neg),
      .mode_i (mode_i),
      .res_o  (fp_res)
    );

    cvt_fp_to_int #(.INT_W(INT_W), .EXP_W(EW_F), .MAN_W(MW_F)) u_f2i (
      .fp_i  (operand_i[FP_W-1:0]),
      .uns_i (op_i[0]),
      .int_o (int_res)
    );

    assign i2f_res[f] = INT_W'(fp_res);
    assign f2i_res[f] = int_res;
  end

  assign res_d = op_i[1] ? f2i_res[fmt_i] : i2f_res[fmt_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) result_o <= '0;
    else         result_o <= res_d;
  end
endmodule

// File: rtl/cvt_unit_chk.sv
module cvt_unit_chk
  import cvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       op_i,
  input logic             fmt_i,
  input logic [1:0]       mode_i,
  input logic [INT_W-1:0] operand_i,
  input logic [INT_W-1:0] result_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_R1: assert (result_o == '0);
  end

  assert_f16_upper_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_i[1] && fmt_i) |=> result_o[INT_W-1:16] == '0);

  assert_float_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FLOAT && !fmt_i && operand_i[INT_W-1]) |=> result_o[31]);

  assert_ufloat_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_UFLOAT && !fmt_i) |=> !result_o[31]);

  assert_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_i[1] && operand_i == '0) |=> result_o == '0);

  assert_inf16_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_UFLOAT && fmt_i && operand_i >= INT_W'(65536)) |=> result_o == INT_W'(16'h7C00));

  assert_nan_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_TRUNC && !fmt_i && operand_i[30:23] == 8'hFF && operand_i[22:0] != '0)
    |=> result_o == {1'b1, {(INT_W-1){1'b0}}});

  assert_uneg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_UTRUNC && !fmt_i && operand_i[31] && operand_i[30:23] != 8'hFF)
    |=> result_o == '0);
endmodule

bind cvt_unit cvt_unit_chk #(.INT_W(INT_W)) u_chk (.*);

// File: tb/tb_cvt_unit.sv
module tb_cvt_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [1:0]  op_i = '0;
  logic        fmt_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [31:0] operand_i = '0;
  logic [31:0] result_o;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    pend = 0;
  bit    done = 0;
  logic [31:0] p_exp;
  string p_tag;

  always #2.5 clk = ~clk;

  cvt_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .fmt_i(fmt_i),
    .mode_i(mode_i), .operand_i(operand_i), .result_o(result_o)
  );

  function automatic logic [31:0] ref_i2f(logic [31:0] x, bit sgn, bit h, logic [1:0] md);
    bit neg;
    longint mag, q, rem, half;
    int e, em, bias, emax, sh;
    bit up;
    em = h ? 10 : 23;  bias = h ? 15 : 127;  emax = h ? 31 : 255;
    neg = sgn && x[31];
    mag = neg ? (64'd4294967296 - longint'(x)) : longint'(x);
    if (mag == 0) return 32'h0;
    e = 0;
    for (int i = 0; i < 40; i++) if (mag >= (64'd1 << i)) e = i;
    rem = 0; half = 0;
    if (e <= em) q = mag << (em - e);
    else begin
      sh = e - em;
      q = mag >> sh;
      rem = mag - (q << sh);
      half = 64'd1 << (sh - 1);
    end
    case (md)
      2'd0: up = (rem > half) || (rem == half && rem != 0 && q[0]);
      2'd1: up = 0;
      2'd2: up = !neg && rem != 0;
      default: up = neg && rem != 0;
    endcase
    q = q + longint'(up);
    if (q == (64'd1 << (em + 1))) begin q = q >> 1; e++; end
    if (e + bias >= emax)
      return h ? {16'h0, neg, 15'h7C00} : {neg, 31'h7F800000};
    if (h) return {16'h0, neg, 5'(e + bias), 10'(q)};
    return {neg, 8'(e + bias), 23'(q)};
  endfunction

  function automatic logic [31:0] ref_f2i(logic [31:0] b, bit h, bit uns);
    bit s, nan, inf;
    int ex, mn, em, bias, emax;
    real v;
    em = h ? 10 : 23;  bias = h ? 15 : 127;  emax = h ? 31 : 255;
    s  = h ? b[15] : b[31];
    ex = h ? int'(b[14:10]) : int'(b[30:23]);
    mn = h ? int'(b[9:0]) : int'(b[22:0]);
    nan = (ex == emax) && mn != 0;
    inf = (ex == emax) && mn == 0;
    if (nan) return uns ? 32'h0 : 32'h80000000;
    if (ex == 0) v = real'(mn) * 2.0 ** real'(1 - bias - em);
    else v = (1.0 + real'(mn) / 2.0 ** real'(em)) * 2.0 ** real'(ex - bias);
    if (s) v = -v;
    if (uns) begin
      if (s) return 32'h0;
      if (inf || v >= 4294967296.0) return 32'hFFFFFFFF;
      if (v >= 2147483648.0) return 32'h80000000 + 32'($rtoi(v - 2147483648.0));
      return 32'($rtoi(v));
    end
    if (inf) return s ? 32'h80000000 : 32'h7FFFFFFF;
    if (v >= 2147483648.0) return 32'h7FFFFFFF;
    if (v <= -2147483649.0) return 32'h80000000;
    return 32'($rtoi(v));
  endfunction

  function automatic logic [31:0] model(logic [1:0] op, bit h, logic [1:0] md, logic [31:0] x);
    if (!op[1]) return ref_i2f(x, !op[0], h, md);
    return ref_f2i(h ? {16'h0, x[15:0]} : x, h, op[0]);
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic settle();
    if (pend) check(result_o, p_exp, p_tag);
  endtask

  task automatic put(logic [1:0] op, bit h, logic [1:0] md, logic [31:0] x,
                     logic [31:0] exp, string tag);
    @(negedge clk);
    settle();
    op_i = op; fmt_i = h; mode_i = md; operand_i = x;
    p_exp = exp; p_tag = tag; pend = 1;
  endtask

  task automatic run(logic [1:0] op, bit h, logic [1:0] md, logic [31:0] x, string tag);
    put(op, h, md, x, model(op, h, md, x), tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lcg;
    lcg = 32'h1234_5678;
    #1 rst_ni = 1'b0;
    op_i = 2'b00; operand_i = 32'd5;
    @(negedge clk); check(result_o, 32'h0, "R1 reset");
    @(negedge clk); check(result_o, 32'h0, "R1 reset held");
    rst_ni = 1'b1;

    // directed
    put(2'b00, 0, 0, 32'd1,         32'h3F800000, "R1 latency float 1");
    put(2'b00, 0, 0, 32'hFFFFFFFF,  32'hBF800000, "R3 float -1");
    put(2'b00, 0, 0, 32'h80000000,  32'hCF000000, "R3 float min int");
    put(2'b01, 0, 0, 32'h80000000,  32'h4F000000, "R3 ufloat msb");
    put(2'b01, 0, 0, 32'hFFFFFFFF,  32'h4F800000, "R5 rne carry");
    put(2'b01, 0, 1, 32'hFFFFFFFF,  32'h4F7FFFFF, "R5 rtz");
    put(2'b00, 0, 2, 32'hFFFFFFFF,  32'hBF800000, "R5 rup exact");
    put(2'b01, 0, 0, 32'h01000001,  32'h4B800000, "R5 tie to even down");
    put(2'b01, 0, 0, 32'h01000003,  32'h4B800002, "R5 tie to even up");
    put(2'b01, 0, 2, 32'h01000001,  32'h4B800001, "R5 rup");
    put(2'b00, 0, 3, 32'hFEFFFFFF,  32'hCB800001, "R5 rdn");
    put(2'b01, 1, 0, 32'd2049,      32'h00006800, "R2 fp16 tie");
    for (int m = 0; m < 4; m++) begin
      put(2'b00, 0, 2'(m), 32'd0,   32'h0, "R4 zero signed");
      put(2'b01, 1, 2'(m), 32'd0,   32'h0, "R4 zero unsigned fp16");
    end
    put(2'b01, 1, 0, 32'd65519,     32'h00007BFF, "R6 below inf");
    put(2'b01, 1, 0, 32'd65520,     32'h00007C00, "R6 carry to inf");
    put(2'b00, 1, 0, -32'sd65520,   32'h0000FC00, "R6 neg inf");
    put(2'b01, 1, 1, 32'd65535,     32'h00007BFF, "R6 rtz no inf");
    put(2'b01, 1, 1, 32'd65536,     32'h00007C00, "R6 rtz inf");
    put(2'b01, 1, 2, 32'd65505,     32'h00007C00, "R6 rup inf");
    put(2'b01, 1, 3, 32'hFFFFFFFF,  32'h00007C00, "R6 big");
    for (int m = 0; m < 4; m++)
      put(2'b10, 0, 2'(m), 32'hC02CCCCD, 32'hFFFFFFFE, "R7 trunc -2.7 any mode");
    put(2'b10, 0, 0, 32'h7FC00000,  32'h80000000, "R8 nan");
    put(2'b10, 0, 0, 32'h7F800000,  32'h7FFFFFFF, "R8 +inf");
    put(2'b10, 0, 0, 32'hFF800000,  32'h80000000, "R8 -inf");
    put(2'b10, 0, 0, 32'h4F32D05E,  32'h7FFFFFFF, "R8 3e9");
    put(2'b10, 0, 0, 32'hCF000000,  32'h80000000, "R8 -2^31 exact");
    put(2'b10, 0, 0, 32'h4EFFFFFF,  32'h7FFFFF80, "R7 largest below 2^31");
    put(2'b11, 0, 0, 32'hBF800000,  32'h0, "R9 negative");
    put(2'b11, 0, 0, 32'hFF800000,  32'h0, "R9 -inf");
    put(2'b11, 0, 0, 32'h7FC00000,  32'h0, "R9 nan");
    put(2'b11, 0, 0, 32'h4F800000,  32'hFFFFFFFF, "R9 2^32");
    put(2'b11, 0, 0, 32'h4F7FFFFF,  32'hFFFFFF00, "R9 below 2^32");
    put(2'b11, 1, 0, 32'h00007C00,  32'hFFFFFFFF, "R9 fp16 +inf");

    // sweeps
    for (int i = 0; i < 65536; i++) run(2'b10, 1, 2'(i), 32'(i), "R7 R8 fp16 trunc sweep");
    for (int i = 0; i < 65536; i += 3) run(2'b11, 1, 2'(i >> 2), 32'(i), "R9 fp16 utrunc sweep");
    for (int m = 0; m < 4; m++)
      for (int i = -70000; i <= 70000; i += 17) run(2'b00, 1, 2'(m), 32'(i), "R5 R6 fp16 float sweep");
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      for (int m = 0; m < 4; m++) begin
        run(2'b00, 0, 2'(m), lcg, "R3 R5 fp32 float");
        run(2'b01, 0, 2'(m), lcg >> (lcg[4:0]), "R5 fp32 ufloat");
      end
      run(2'b10, 0, lcg[1:0], {lcg[31], 8'(8'd110 + 8'(lcg[7:0] % 50)), lcg[30:8]}, "R7 R8 fp32 trunc");
      run(2'b11, 0, lcg[3:2], {lcg[31], 8'(8'd110 + 8'(lcg[15:8] % 50)), lcg[30:8]}, "R9 fp32 utrunc");
    end
    @(negedge clk);
    settle();
    pend = 0;
    finish_run();
  end
endmodule